// File: doc/BRIEF.md
# Split-Read 40-bit Timestamp Counter

This block keeps a 40-bit timestamp that counts up by one on each cycle where an external tick strobe is high and counting is enabled. Software reads it over a 32-bit register bus in two accesses. Reading the low-word register returns count bits 31:0 and, in the same clock edge, copies bits 39:32 into a shadow byte. A later read of the high register returns that shadow byte. The two words therefore belong to the same instant, even if the counter has carried into its upper byte between the two accesses.

The high register also holds the count enable in bit 8. Writing it starts or stops counting and changes nothing else. The block has no interrupt output. The counter's reset value is a parameter, zero by default, so that a verification build can start close to a carry or a wrap.

Top module: `tstamp_split_counter`

## Requirements
- R1: After reset the count is CNT_RESET (0 by default), the enable is 0 and the shadow byte is 0, so a first read of the high register returns 0.
- R2: The count advances by exactly one on each clock edge where tickStb is 1 and the enable is 1. A tick while the enable is 0 leaves the count unchanged.
- R3: A read (rdEn=1) at address 0x60 presents count bits 31:0 on rdData after the next clock edge. rdData holds its value until the next read.
- R4: A read at 0x60 copies count bits 39:32 into the shadow byte. A read at 0x64 returns the shadow byte in bits 7:0, the enable in bit 8, and 0 in all other bits.
- R5: A write (wrEn=1) at 0x64 sets the enable to wrData bit 8. It changes neither the count nor the shadow byte, and other wrData bits have no effect.
- R6: Address 0x60 is read-only. A write there does not change the enable, the count or the shadow byte.
- R7: When a tick and a 0x60 read fall in the same cycle, the returned low word and the captured byte both come from the value before that increment.
- R8: The count wraps from all-ones (40'hFF_FFFF_FFFF) to 0.
- R9: A read at any other address returns 0.
- R10: Ticks and high-register reads do not alter the shadow byte. Only a 0x60 read does, so a low-then-high pair stays consistent when a carry into bit 32 happens between the two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickStb | input | 1 | Count strobe, one increment per high cycle |
| rdEn | input | 1 | Register read request |
| wrEn | input | 1 | Register write request |
| addr | input | 8 | Register byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered, valid one cycle after rdEn |

## Verification
The hardest conditions to reach from the ports are a carry from bit 31 into the upper byte and the wrap from all-ones to 0. Ticks alone would take about 2^32 and 2^40 cycles to get there. The bench therefore builds two extra copies of the block whose CNT_RESET sits just below each boundary, and drives all three copies with the same bus stimulus. It reads the low word, ticks across the boundary, then reads the high word, and checks that the high read returns the byte captured before the carry. The same-cycle tick and low-read collision is driven directly from the vector table.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  typedef struct packed {
    logic rdLow;
    logic rdHigh;
    logic rdOther;
    logic setEn;
    logic enVal;
  } tsStrb_t;
endpackage

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl
  import tstamp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int EN_BIT    = 8,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 8'h60,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 8'h64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output tsStrb_t           strb
);
  logic hitLow;
  logic hitHigh;
  logic wrUnused;

  assign hitLow   = (addr == LOW_ADDR);
  assign hitHigh  = (addr == HIGH_ADDR);
  assign wrUnused = ^wrData;

  always_comb begin
    strb         = '0;
    strb.rdLow   = rdEn && hitLow;
    strb.rdHigh  = rdEn && hitHigh;
    strb.rdOther = rdEn && !hitLow && !hitHigh;
    strb.setEn   = wrEn && hitHigh;
    strb.enVal   = wrData[EN_BIT];
  end

  AST_LOW_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hitLow) |-> !strb.setEn); // R6
endmodule

// File: rtl/tstamp_datapath.sv
module tstamp_datapath
  import tstamp_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int DATA_W = 32,
  parameter int EN_BIT = 8,
  parameter logic [CNT_W-1:0] CNT_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickStb,
  input  tsStrb_t           strb,
  output logic [DATA_W-1:0] rdData
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0]  cnt;
  logic [HI_W-1:0]   shadow;
  logic              en;
  logic [DATA_W-1:0] hiWord;
  logic              step;

  assign step = en && tickStb;

  always_comb begin
    hiWord             = '0;
    hiWord[HI_W-1:0]   = shadow;
    hiWord[EN_BIT]     = en;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= CNT_RESET;
    end else if (step) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow <= '0;
      en     <= 1'b0;
    end else begin
      if (strb.rdLow) shadow <= cnt[CNT_W-1:DATA_W];
      if (strb.setEn) en     <= strb.enVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdLow) begin
      rdData <= cnt[DATA_W-1:0];
    end else if (strb.rdHigh) begin
      rdData <= hiWord;
    end else if (strb.rdOther) begin
      rdData <= '0;
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    step |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1)))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable(cnt)); // R2
  AST_LOW_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdLow |=> (rdData == $past(cnt[DATA_W-1:0]))); // R3
  AST_LATCH_PRE: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdLow |=> (shadow == $past(cnt[CNT_W-1:DATA_W]))); // R7
  AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdLow |=> $stable(shadow)); // R10
  AST_HIGH_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdHigh |=> (rdData[HI_W-1:0] == $past(shadow))); // R4
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEn |=> (en == $past(strb.enVal))); // R5
  AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdOther |=> (rdData == '0)); // R9
endmodule

// File: rtl/tstamp_split_counter.sv
module tstamp_split_counter
  import tstamp_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int EN_BIT = 8,
  parameter logic [CNT_W-1:0] CNT_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickStb,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  tsStrb_t strb;

  tstamp_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .strb(strb)
  );

  tstamp_datapath #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT), .CNT_RESET(CNT_RESET)
  ) uData (
    .clk(clk), .rstN(rstN), .tickStb(tickStb), .strb(strb), .rdData(rdData)
  );
endmodule

// File: tb/sim_tstamp_split_counter.sv
module sim_tstamp_split_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickStb = 1'b0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rd0, rd1, rd2;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tstamp_split_counter u0 (.clk(clk), .rstN(rstN), .tickStb(tickStb), .rdEn(rdEn),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rd0));
  tstamp_split_counter #(.CNT_RESET(40'h0F_FFFF_FFFF)) u1 (.clk(clk), .rstN(rstN),
    .tickStb(tickStb), .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rd1));
  tstamp_split_counter #(.CNT_RESET(40'hFF_FFFF_FFFF)) u2 (.clk(clk), .rstN(rstN),
    .tickStb(tickStb), .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rd2));

  // entry: op[74:73] (0 idle,1 read,2 write), addr[72:65], wdata[64:33], tick[32], expect[31:0]
  localparam int NV = 16;
  localparam logic [74:0] VEC [NV] = '{
    {2'd1, 8'h64, 32'h0,         1'b0, 32'h0},        // R1 high after reset
    {2'd0, 8'h00, 32'h0,         1'b1, 32'h0},        // R2 tick while disabled
    {2'd1, 8'h60, 32'h0,         1'b0, 32'h0},        // R2 still zero
    {2'd2, 8'h64, 32'h100,       1'b0, 32'h0},        // R5 enable
    {2'd0, 8'h00, 32'h0,         1'b1, 32'h0},
    {2'd0, 8'h00, 32'h0,         1'b1, 32'h0},
    {2'd1, 8'h60, 32'h0,         1'b0, 32'h2},        // R3 two ticks
    {2'd1, 8'h64, 32'h0,         1'b0, 32'h100},      // R4 en bit, shadow 0
    {2'd2, 8'h60, 32'hFFFF_FFFF, 1'b1, 32'h0},        // R6 write to low ignored
    {2'd1, 8'h60, 32'h0,         1'b1, 32'h3},        // R7 tick with read
    {2'd1, 8'h60, 32'h0,         1'b0, 32'h4},        // R7 increment landed
    {2'd1, 8'h20, 32'h0,         1'b0, 32'h0},        // R9 other address
    {2'd2, 8'h64, 32'hFFFF_FEFF, 1'b0, 32'h0},        // R5 disable, other bits ignored
    {2'd0, 8'h00, 32'h0,         1'b1, 32'h0},
    {2'd1, 8'h64, 32'h0,         1'b0, 32'h0},        // R5 en cleared
    {2'd1, 8'h60, 32'h0,         1'b0, 32'h4}         // R2 R5 count held
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [7:0] a, input logic [31:0] wd,
                       input logic tk);
    rdEn = (op == 2'd1);
    wrEn = (op == 2'd2);
    addr = a;
    wrData = wd;
    tickStb = tk;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0; tickStb = 1'b0; addr = '0; wrData = '0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 rdData after reset", rd0, 32'h0);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][74:73], VEC[i][72:65], VEC[i][64:33], VEC[i][32]);
      if (VEC[i][74:73] == 2'd1) chk($sformatf("vector %0d", i), rd0, VEC[i][31:0]);
    end

    // reset again, then directed boundary tests across all three copies
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    drive(2'd1, 8'h64, 32'h0, 1'b0);
    chk("R1 u0 high", rd0, 32'h0);
    chk("R1 u1 high", rd1, 32'h0);
    drive(2'd1, 8'h60, 32'h0, 1'b0);
    chk("R1 u0 low", rd0, 32'h0);
    chk("R1 u1 low preset", rd1, 32'hFFFF_FFFF);
    drive(2'd2, 8'h64, 32'h100, 1'b0);
    drive(2'd1, 8'h60, 32'h0, 1'b0);
    chk("R3 u1 low before carry", rd1, 32'hFFFF_FFFF);
    chk("R3 u2 low before wrap", rd2, 32'hFFFF_FFFF);
    drive(2'd0, 8'h00, 32'h0, 1'b1);
    drive(2'd1, 8'h64, 32'h0, 1'b0);
    chk("R10 u1 high keeps pre-carry byte", rd1, 32'h10F);
    chk("R10 u2 high keeps pre-wrap byte", rd2, 32'h1FF);
    chk("R4 u0 high", rd0, 32'h100);
    drive(2'd1, 8'h60, 32'h0, 1'b0);
    chk("R2 u0 low", rd0, 32'h1);
    chk("R2 u1 low after carry", rd1, 32'h0);
    chk("R8 u2 low after wrap", rd2, 32'h0);
    drive(2'd1, 8'h64, 32'h0, 1'b0);
    chk("R4 u1 high after carry", rd1, 32'h110);
    chk("R8 u2 high after wrap", rd2, 32'h100);
    drive(2'd2, 8'h60, 32'h0, 1'b0);
    drive(2'd1, 8'h64, 32'h0, 1'b0);
    chk("R6 u1 high after low write", rd1, 32'h110);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule